// File: doc/BRIEF.md
# Latched Interrupt Aggregator with Software Force and Clear

This block gathers five single-cycle event inputs: a buffer-level trigger, a buffer underflow, a buffer overflow and two timer overflows. Each event is held in its own sticky flag. The flags are ANDed with a per-source enable mask. A global interrupt latch then turns the result into one interrupt pulse. Once that pulse has fired, the latch stays set and blocks further pulses until software clears it. If any enabled flag is still pending at that point, the clear immediately re-arms a new pulse.

Software reaches the block through a small 32-bit word-addressed register port. The port has four words: the flag word (read only), the enable word (read/write), a force word (write-1-to-set, reads as zero) and a clear word (write-1-to-clear, reads as zero). Reads are combinational from the addressed word. A write takes effect at the clock edge where it is presented.

Top module: `irq_latch_agg`

## Requirements
- R1: After a synchronous active-low reset, every source flag, every enable bit and the global latch are 0, and `irq_o` is low.
- R2: A high level on `evt_i[k]` at a clock edge sets source flag bit k+1 of the flag word (address 0). Bit 5 is the buffer trigger, bit 4 underflow, bit 3 overflow, bit 2 timer-2 overflow, bit 1 timer-1 overflow. The flag stays set until it is cleared.
- R3: A write to address 2 sets every flag whose bit 5..1 in the write data is 1. Reading address 2 always returns 0.
- R4: A write to address 3 clears every flag (bits 5..1) and the global latch (bit 0) whose data bit is 1. Zero bits in that write leave state untouched, and reading address 3 returns 0.
- R5: If an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R6: Address 1 holds the enables in bits 5..1 and can be read back. Bit 0 always reads 0.
- R7: When the global latch is 0 and some flag is both set and enabled, `irq_o` goes high for exactly one cycle on the next edge. Bit 0 of the flag word becomes 1 at that same edge.
- R8: While the global latch is 1, `irq_o` stays low whatever flags are raised.
- R9: Clearing the global latch while an enabled flag is still set produces a new pulse on the edge after the clear takes effect. With no such flag, no pulse follows.
- R10: A flag whose enable is 0 is still latched but causes no pulse. Enabling it later, while the latch is 0, fires a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 5 | Event pulses; bit k feeds flag bit k+1 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address: 0 flags, 1 enables, 2 force, 3 clear |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed word |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
An event or force write presented before edge N appears in the flag word after edge N. If it is enabled and the latch is open, it produces `irq_o` after edge N+1, two cycles after it was driven. A latch clear or an enable write follows the same two-edge path to a new pulse. The driver pushes the cycle number at which each pulse is due into a queue as it drives the stimulus. A monitor on the falling edge pops that entry when `irq_o` is high and flags any pulse that comes early, late or unasked. Register reads are sampled half a cycle after the address settles, so they always see the state left by completed edges.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int SRC_N  = 5;
    localparam int REG_AW = 2;
    localparam int REG_DW = 32;

    typedef enum logic [REG_AW-1:0] {
        RA_FLAG  = 2'd0,
        RA_ENAB  = 2'd1,
        RA_FORCE = 2'd2,
        RA_CLEAR = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irqagg_regs.sv
// Register port decode: keeps the enable mask, turns force and clear writes
// into one-cycle strobes and muxes read data. Assumes DW > N.
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int N  = SRC_N,
    parameter int AW = REG_AW,
    parameter int DW = REG_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [N-1:0]  flags_i,
    input  logic          latch_i,
    output logic [N-1:0]  en_o,
    output logic [N-1:0]  set_o,
    output logic [N-1:0]  clr_o,
    output logic          clr_latch_o,
    output logic [DW-1:0] rdata_o
);
    logic unused_hi;
    assign unused_hi = ^wdata_i[DW-1:N+1];

    // Enable mask storage, written at address 1
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_o <= '0;
        else if (wr_i && addr_i == RA_ENAB)
            en_o <= wdata_i[N:1];
    end

    // Write-one strobes for force and clear
    always_comb begin
        set_o       = (wr_i && addr_i == RA_FORCE) ? wdata_i[N:1] : '0;
        clr_o       = (wr_i && addr_i == RA_CLEAR) ? wdata_i[N:1] : '0;
        clr_latch_o = wr_i && addr_i == RA_CLEAR && wdata_i[0];
    end

    // Read mux; force and clear words read as zero
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            RA_FLAG: rdata_o[N:0] = {flags_i, latch_i};
            RA_ENAB: rdata_o[N:0] = {en_o, 1'b0};
            default: rdata_o = '0;
        endcase
    end

    assert_en_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == RA_ENAB) |=> (en_o == $past(wdata_i[N:1])));
endmodule

// File: rtl/irqagg_flags.sv
// Sticky per-source flags. Hardware events and force strobes set a flag,
// clear strobes reset it, and a set always beats a clear in the same cycle.
module irqagg_flags #(
    parameter int N = irqagg_pkg::SRC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar k = 0; k < N; k++) begin : g_flag
        // One flag bit: set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_o[k] <= 1'b0;
            else if (evt_i[k] || set_i[k])
                flags_o[k] <= 1'b1;
            else if (clr_i[k])
                flags_o[k] <= 1'b0;
        end

        assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[k] |=> flags_o[k]);
        assert_force_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> flags_o[k]);
        assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !evt_i[k] && !set_i[k]) |=> !flags_o[k]);
        assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && evt_i[k]) |=> flags_o[k]);
    end
endmodule

// File: rtl/irqagg_gate.sv
// Global latch and pulse generator. Fires one registered pulse when the latch
// is open and some enabled flag is set; the pulse closes the latch, and only
// a software clear reopens it.
module irqagg_gate #(
    parameter int N = irqagg_pkg::SRC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] en_i,
    input  logic         clr_latch_i,
    output logic         latch_o,
    output logic         irq_o
);
    logic fire;
    assign fire = !latch_o && |(flags_i & en_i);

    // Latch closes on a pulse and opens on a software clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_o <= 1'b0;
            irq_o   <= 1'b0;
        end else begin
            irq_o <= fire;
            if (fire)
                latch_o <= 1'b1;
            else if (clr_latch_i)
                latch_o <= 1'b0;
        end
    end

    assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    assert_pulse_with_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> latch_o);
    assert_latch_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |=> !irq_o);
    assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_o && |(flags_i & en_i)) |=> irq_o);
endmodule

// File: rtl/irq_latch_agg.sv
// Top of the interrupt aggregator: register port, sticky flags and global
// latch. Assumes event inputs are synchronous to clk.
module irq_latch_agg
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  evt_i,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    output logic              irq_o
);
    logic [SRC_N-1:0] flags, en, set_v, clr_v;
    logic             latch, clr_latch;

    irqagg_regs #(.N(SRC_N), .AW(REG_AW), .DW(REG_DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .flags_i(flags), .latch_i(latch),
        .en_o(en), .set_o(set_v), .clr_o(clr_v), .clr_latch_o(clr_latch),
        .rdata_o(reg_rdata_o)
    );

    irqagg_flags #(.N(SRC_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .set_i(set_v),
        .clr_i(clr_v), .flags_o(flags)
    );

    irqagg_gate #(.N(SRC_N)) u_gate (
        .clk(clk), .rst_n(rst_n), .flags_i(flags), .en_i(en),
        .clr_latch_i(clr_latch), .latch_o(latch), .irq_o(irq_o)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && flags == '0 && en == '0 && !latch));
    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |=> !irq_o);
endmodule

// File: tb/test_irq_latch_agg.sv
module test_irq_latch_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  evt = '0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int exp_q[$];
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irq_latch_agg i_irq_latch_agg (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops due pulse cycles and compares them with irq
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                checks++; fails++;
                $display("FAIL R7 pulse missing: actual none at %0d expected at %0d", cyc, exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (irq) begin
                checks++;
                if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                    void'(exp_q.pop_front());
                end else begin
                    fails++;
                    $display("FAIL R8 unexpected pulse: actual 1 at %0d expected 0", cyc);
                end
            end
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d, input bit fire);
        @(negedge clk);
        if (fire) exp_q.push_back(cyc + 2);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic pulse_evt(input logic [4:0] m, input bit fire);
        @(negedge clk);
        if (fire) exp_q.push_back(cyc + 2);
        evt = m;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rdata !== e) begin
            fails++;
            $display("FAIL %s addr %0d: actual %h expected %h", req, a, rdata, e);
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (irq !== 1'b0) begin fails++; $display("FAIL R1 irq: actual %b expected 0", irq); end
        rst_n = 1'b1;
        rd_chk(2'd0, 32'h0, "R1");
        rd_chk(2'd1, 32'h0, "R1");

        reg_wr(2'd1, 32'hFFFF_FFFF, 1'b0);
        rd_chk(2'd1, 32'h3E, "R6");                 // bit 0 reads 0

        pulse_evt(5'b00001, 1'b1);                  // timer-1 -> bit 1, fires
        rd_chk(2'd0, 32'h03, "R2 R7");

        pulse_evt(5'b10000, 1'b0);                  // latch closed: no pulse
        rd_chk(2'd0, 32'h23, "R8");

        reg_wr(2'd3, 32'h0, 1'b0);                  // zeros clear nothing
        rd_chk(2'd0, 32'h23, "R4");

        reg_wr(2'd3, 32'h01, 1'b1);                 // reopen latch, re-fires
        rd_chk(2'd0, 32'h23, "R9");

        reg_wr(2'd3, 32'h3F, 1'b0);
        rd_chk(2'd0, 32'h00, "R4");
        rd_chk(2'd3, 32'h00, "R4");

        reg_wr(2'd2, 32'h04, 1'b1);                 // force timer-2 flag
        rd_chk(2'd2, 32'h00, "R3");
        rd_chk(2'd0, 32'h05, "R3");

        reg_wr(2'd3, 32'h3F, 1'b0);
        reg_wr(2'd1, 32'h02, 1'b0);                 // only bit 1 enabled

        @(negedge clk);                             // event and clear on bit 3
        evt = 5'b00100; wr = 1'b1; addr = 2'd3; wdata = 32'h08;
        @(negedge clk);
        evt = '0; wr = 1'b0; wdata = '0;
        rd_chk(2'd0, 32'h08, "R5 R10");

        reg_wr(2'd1, 32'h08, 1'b1);                 // enabling pending flag fires
        rd_chk(2'd0, 32'h09, "R10");

        reg_wr(2'd3, 32'h09, 1'b0);                 // nothing pending: no re-fire
        rd_chk(2'd0, 32'h00, "R9");

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R7 pending pulses: actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule